// File: doc/BRIEF.md
# Simplex Inter-Processor Mailbox

This block is a one-way message channel between two bus masters that share a chip. The sending master posts one message through its own small register port. A message is two 32-bit words: a pointer (or data) word and a command word. Taken together they form a 64-bit message, with the command word in the low half and the pointer word in the high half. The receiving master is told of a pending message by an interrupt, and it collects the message through a second register port. A link that carries traffic both ways uses two instances, one for each direction.

Delivery is atomic and the command word commits it. The sender writes the pointer word first and the command word last. The command write marks the slot full and makes both words visible to the receiver. The receiver reads the pointer word first, which has no side effect. Its read of the command word then consumes the message and frees the slot. The slot holds one message at a time. The two states of its state machine are named below. SLOT_EMPTY goes to SLOT_FULL on a command write (transition POST). SLOT_FULL returns to SLOT_EMPTY on a command read (transition TAKE). SLOT_FULL stays in SLOT_FULL when a command read and a command write arrive in the same cycle (transition REFILL). It also stays in SLOT_FULL when a command write arrives without a read (transition REJECT), which sets the overflow flag.

Both ports decode the same register offsets. Offset 0 is the command word and offset 1 is the pointer word. Offset 2 is status, with bit 0 full, bit 1 empty and bit 2 overflow. Offset 3 is interrupt control and exists on the receiver port only: bit 0 is the pending-enable bit.

Top module: `ipc_mailbox_simplex`

## Requirements
- R1: After reset, status reads 2 on both ports (empty set, full and overflow clear). Offsets 0, 1 and 3 read 0 on the receiver port, and irq is 0.
- R2: A sender write to offset 1 alone does not post a message. A following write to offset 0 sets status to full (value 1) from the next cycle on, and the receiver then reads back both written words.
- R3: A receiver read of offset 1 has no side effect. A receiver read of offset 0 while the slot is full clears the full flag at that clock edge, so status reads empty (value 2) in the next cycle.
- R4: irq is 1 in the cycle after one in which the slot is full and the pending-enable bit is set. irq returns to 0 one cycle after the full flag clears.
- R5: On the receiver port, a write to offset 3 loads bit 0 into the pending-enable bit, and the bit reads back at offset 3. While the bit is 0, irq stays 0 even when a message is pending. Setting it again raises irq for a pending message.
- R6: A sender write to offset 0 while the slot is full, with no command read in the same cycle, is ignored. It sets overflow (status bit 2), which stays set until reset, even after the pending message is consumed.
- R7: A sender write to offset 1 while the slot is full, with no command read in the same cycle, is ignored, and the pending pointer word is unchanged.
- R8: Reads of offsets 0 and 1 while the slot is empty return the last stored words and change no state.
- R9: When a command read and a command write arrive in the same cycle on a full slot, the read returns the old command word. The new message is accepted, the slot stays full, and overflow is not set.
- R10: The receiver cannot write the message words (writes to offsets 0 and 1 on the receiver port are ignored), and the sender port reads 0 at offset 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_wr | input | 1 | Sender write strobe |
| snd_addr | input | 2 | Sender register offset |
| snd_wdata | input | 32 | Sender write data |
| snd_rdata | output | 32 | Sender read data (combinational on snd_addr) |
| rcv_wr | input | 1 | Receiver write strobe |
| rcv_rd | input | 1 | Receiver read strobe (consumes on offset 0) |
| rcv_addr | input | 2 | Receiver register offset |
| rcv_wdata | input | 32 | Receiver write data |
| rcv_rdata | output | 32 | Receiver read data (combinational on rcv_addr) |
| irq | output | 1 | Message-pending interrupt to the receiver |

## Verification
The main handshake is swept over sixteen messages. Each message's words are computed from its index, so a word that is lost, swapped between offsets or stale from an earlier message shows up as a wrong value. Separate sequences cover reading while empty, masking and unmasking the interrupt on a pending message, posting into a full slot, and a same-cycle consume and post. These sequences tell apart an ignored write from an accepted one, and they separate the sticky overflow flag from the full flag. Between the sequences a reset is applied, so that overflow from one sequence cannot hide a wrongly set flag in the next.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int OFS_W = 2;

    typedef enum logic [OFS_W-1:0] {
        OFS_CMD  = 2'd0,
        OFS_PTR  = 2'd1,
        OFS_STAT = 2'd2,
        OFS_IEN  = 2'd3
    } mbx_ofs_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    localparam int STAT_FULL_BIT  = 0;
    localparam int STAT_EMPTY_BIT = 1;
    localparam int STAT_OVF_BIT   = 2;
    localparam int STAT_BITS      = 3;

endpackage

// File: rtl/mbx_sender_port.sv
module mbx_sender_port
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 snd_wr,
    input  logic [OFS_W-1:0]     snd_addr,
    input  logic [DATA_W-1:0]    cmd_q,
    input  logic [DATA_W-1:0]    ptr_q,
    input  logic [STAT_BITS-1:0] stat,
    output logic                 post_cmd,
    output logic                 post_ptr,
    output logic [DATA_W-1:0]    snd_rdata
);

    localparam int PAD_W = DATA_W - STAT_BITS;

    always_comb begin
        post_cmd = snd_wr && (mbx_ofs_e'(snd_addr) == OFS_CMD);
        post_ptr = snd_wr && (mbx_ofs_e'(snd_addr) == OFS_PTR);
    end

    always_comb begin
        unique case (mbx_ofs_e'(snd_addr))
            OFS_CMD:  snd_rdata = cmd_q;
            OFS_PTR:  snd_rdata = ptr_q;
            OFS_STAT: snd_rdata = {{PAD_W{1'b0}}, stat};
            OFS_IEN:  snd_rdata = '0;
            default:  snd_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_cmd,
    input  logic              post_ptr,
    input  logic              take_req,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] ptr_q,
    output logic              full,
    output logic              ovf
);

    slot_state_e state, state_nxt;
    logic        take;
    logic        acc_cmd;
    logic        acc_ptr;
    logic        ovf_set;
    logic        ovf_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= state_nxt;
    end

    // transitions: POST, TAKE, REFILL, REJECT
    always_comb begin
        state_nxt = state;
        unique case (state)
            SLOT_EMPTY: if (post_cmd)            state_nxt = SLOT_FULL;
            SLOT_FULL:  if (take_req && !post_cmd) state_nxt = SLOT_EMPTY;
            default:                             state_nxt = SLOT_EMPTY;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        take    = 1'b0;
        acc_cmd = 1'b0;
        acc_ptr = 1'b0;
        ovf_set = 1'b0;
        unique case (state)
            SLOT_EMPTY: begin
                acc_cmd = post_cmd;
                acc_ptr = post_ptr;
            end
            SLOT_FULL: begin
                take    = take_req;
                acc_cmd = post_cmd && take_req;
                acc_ptr = post_ptr && take_req;
                ovf_set = post_cmd && !take_req;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            ptr_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (acc_cmd) cmd_q <= wdata;
            if (acc_ptr) ptr_q <= wdata;
            if (ovf_set) ovf_q <= 1'b1;
        end
    end

    assign full = (state == SLOT_FULL);
    assign ovf  = ovf_q;

    logic unused_take;
    assign unused_take = take;

endmodule

// File: rtl/mbx_receiver_port.sv
module mbx_receiver_port
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rcv_wr,
    input  logic                 rcv_rd,
    input  logic [OFS_W-1:0]     rcv_addr,
    input  logic [DATA_W-1:0]    rcv_wdata,
    input  logic [DATA_W-1:0]    cmd_q,
    input  logic [DATA_W-1:0]    ptr_q,
    input  logic [STAT_BITS-1:0] stat,
    input  logic                 full,
    output logic                 take_req,
    output logic                 ien_q,
    output logic                 irq,
    output logic [DATA_W-1:0]    rcv_rdata
);

    localparam int PAD_W  = DATA_W - STAT_BITS;
    localparam int IPAD_W = DATA_W - 1;

    logic irq_q;
    logic ien_wr;

    always_comb begin
        take_req = rcv_rd && (mbx_ofs_e'(rcv_addr) == OFS_CMD);
        ien_wr   = rcv_wr && (mbx_ofs_e'(rcv_addr) == OFS_IEN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (ien_wr) ien_q <= rcv_wdata[0];
            irq_q <= full && ien_q;
        end
    end

    assign irq = irq_q;

    always_comb begin
        unique case (mbx_ofs_e'(rcv_addr))
            OFS_CMD:  rcv_rdata = cmd_q;
            OFS_PTR:  rcv_rdata = ptr_q;
            OFS_STAT: rcv_rdata = {{PAD_W{1'b0}}, stat};
            OFS_IEN:  rcv_rdata = {{IPAD_W{1'b0}}, ien_q};
            default:  rcv_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ipc_mailbox_simplex.sv
module ipc_mailbox_simplex
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_wr,
    input  logic [1:0]        snd_addr,
    input  logic [DATA_W-1:0] snd_wdata,
    output logic [DATA_W-1:0] snd_rdata,
    input  logic              rcv_wr,
    input  logic              rcv_rd,
    input  logic [1:0]        rcv_addr,
    input  logic [DATA_W-1:0] rcv_wdata,
    output logic [DATA_W-1:0] rcv_rdata,
    output logic              irq
);

    logic                 post_cmd;
    logic                 post_ptr;
    logic                 take_req;
    logic [DATA_W-1:0]    cmd_q;
    logic [DATA_W-1:0]    ptr_q;
    logic                 full_q;
    logic                 ovf_q;
    logic                 ien_q;
    logic [STAT_BITS-1:0] stat;

    always_comb begin
        stat                 = '0;
        stat[STAT_FULL_BIT]  = full_q;
        stat[STAT_EMPTY_BIT] = !full_q;
        stat[STAT_OVF_BIT]   = ovf_q;
    end

    mbx_sender_port #(.DATA_W(DATA_W)) u_snd (
        .snd_wr    (snd_wr),
        .snd_addr  (snd_addr),
        .cmd_q     (cmd_q),
        .ptr_q     (ptr_q),
        .stat      (stat),
        .post_cmd  (post_cmd),
        .post_ptr  (post_ptr),
        .snd_rdata (snd_rdata)
    );

    mbx_slot #(.DATA_W(DATA_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .post_cmd (post_cmd),
        .post_ptr (post_ptr),
        .take_req (take_req),
        .wdata    (snd_wdata),
        .cmd_q    (cmd_q),
        .ptr_q    (ptr_q),
        .full     (full_q),
        .ovf      (ovf_q)
    );

    mbx_receiver_port #(.DATA_W(DATA_W)) u_rcv (
        .clk       (clk),
        .rst_n     (rst_n),
        .rcv_wr    (rcv_wr),
        .rcv_rd    (rcv_rd),
        .rcv_addr  (rcv_addr),
        .rcv_wdata (rcv_wdata),
        .cmd_q     (cmd_q),
        .ptr_q     (ptr_q),
        .stat      (stat),
        .full      (full_q),
        .take_req  (take_req),
        .ien_q     (ien_q),
        .irq       (irq),
        .rcv_rdata (rcv_rdata)
    );

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              post_cmd,
    input logic              post_ptr,
    input logic              take_req,
    input logic              full_q,
    input logic              ovf_q,
    input logic              ien_q,
    input logic              irq,
    input logic [DATA_W-1:0] cmd_q,
    input logic [DATA_W-1:0] ptr_q
);

    AST_POST_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (post_cmd && !full_q) |=> full_q); // R2

    AST_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && full_q && !post_cmd) |=> !full_q); // R3

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |=> !irq); // R5

    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !full_q |=> !irq); // R4

    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q); // R6

    AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !take_req) |=> ($stable(cmd_q) && $stable(ptr_q))); // R7

    AST_REFILL_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && take_req && post_cmd && !ovf_q) |=> (full_q && !ovf_q)); // R9

    logic unused_ptr;
    assign unused_ptr = post_ptr;

endmodule

bind ipc_mailbox_simplex mbx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .post_cmd (post_cmd),
    .post_ptr (post_ptr),
    .take_req (take_req),
    .full_q   (full_q),
    .ovf_q    (ovf_q),
    .ien_q    (ien_q),
    .irq      (irq),
    .cmd_q    (cmd_q),
    .ptr_q    (ptr_q)
);

// File: tb/tb_ipc_mailbox_simplex.sv
`timescale 1ns/1ps
module tb_ipc_mailbox_simplex;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snd_wr = 1'b0;
    logic [1:0]    snd_addr = '0;
    logic [DW-1:0] snd_wdata = '0;
    logic [DW-1:0] snd_rdata;
    logic          rcv_wr = 1'b0;
    logic          rcv_rd = 1'b0;
    logic [1:0]    rcv_addr = '0;
    logic [DW-1:0] rcv_wdata = '0;
    logic [DW-1:0] rcv_rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ipc_mailbox_simplex #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .snd_wr(snd_wr), .snd_addr(snd_addr), .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
        .rcv_wr(rcv_wr), .rcv_rd(rcv_rd), .rcv_addr(rcv_addr), .rcv_wdata(rcv_wdata),
        .rcv_rdata(rcv_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic snd_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); snd_addr = a; snd_wdata = d; snd_wr = 1'b1;
        @(negedge clk); snd_wr = 1'b0;
    endtask

    task automatic rcv_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); rcv_addr = a; rcv_wdata = d; rcv_wr = 1'b1;
        @(negedge clk); rcv_wr = 1'b0;
    endtask

    task automatic rcv_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk); rcv_addr = a; rcv_rd = 1'b1;
        #1 d = rcv_rdata;
        @(negedge clk); rcv_rd = 1'b0;
    endtask

    task automatic snd_peek(input logic [1:0] a, output logic [DW-1:0] d);
        snd_addr = a;
        #1 d = snd_rdata;
    endtask

    function automatic logic [DW-1:0] mk_cmd(input int i);
        return 32'h1000_0003 + 32'h0101_0101 * i;
    endfunction

    function automatic logic [DW-1:0] mk_ptr(input int i);
        return ~mk_cmd(i) ^ (32'h0000_0010 << i);
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] v;
        do_reset();

        // R1 reset state
        rcv_read(2, v); check("R1 rcv status", v, 32'd2);
        snd_peek(2, v); check("R1 snd status", v, 32'd2);
        rcv_read(0, v); check("R1 cmd", v, 32'd0);
        rcv_read(1, v); check("R1 ptr", v, 32'd0);
        rcv_read(3, v); check("R1 ien", v, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R5 enable readback
        rcv_write(3, 32'hFFFF_FFF1);
        rcv_read(3, v); check("R5 ien set", v, 32'd1);

        // R2 R3 R4 sweep over sixteen messages
        for (int i = 0; i < 16; i++) begin
            snd_write(1, mk_ptr(i));
            snd_peek(2, v); check("R2 ptr alone no post", v, 32'd2);
            snd_write(0, mk_cmd(i));
            snd_peek(2, v); check("R2 full after cmd", v, 32'd1);
            idle(1);
            check("R4 irq up", {31'd0, irq}, 32'd1);
            rcv_read(1, v); check("R2 ptr", v, mk_ptr(i));
            rcv_read(2, v); check("R3 ptr read no side effect", v, 32'd1);
            rcv_read(0, v); check("R2 cmd", v, mk_cmd(i));
            rcv_read(2, v); check("R3 empty after cmd read", v, 32'd2);
            check("R4 irq down", {31'd0, irq}, 32'd0);
        end

        // R8 reads when empty
        rcv_read(0, v); check("R8 cmd last", v, mk_cmd(15));
        rcv_read(1, v); check("R8 ptr last", v, mk_ptr(15));
        rcv_read(2, v); check("R8 still empty", v, 32'd2);
        check("R8 irq", {31'd0, irq}, 32'd0);

        // R5 mask and unmask
        rcv_write(3, 32'd0);
        snd_write(1, 32'hCAFE_0001);
        snd_write(0, 32'hBEEF_0002);
        idle(2);
        check("R5 masked irq", {31'd0, irq}, 32'd0);
        rcv_read(3, v); check("R5 ien clear", v, 32'd0);
        rcv_write(3, 32'd1);
        idle(1);
        check("R5 unmasked irq", {31'd0, irq}, 32'd1);

        // R6 R7 posting into a full slot
        snd_write(1, 32'h5555_AAAA);
        snd_write(0, 32'h6666_BBBB);
        snd_peek(2, v); check("R6 full+overflow", v, 32'd5);
        rcv_read(1, v); check("R7 ptr kept", v, 32'hCAFE_0001);
        rcv_read(0, v); check("R6 cmd kept", v, 32'hBEEF_0002);
        rcv_read(2, v); check("R6 overflow sticky", v, 32'd6);

        // R9 same-cycle consume and post
        do_reset();
        rcv_read(2, v); check("R1 status after reset", v, 32'd2);
        snd_write(1, 32'h0000_0B01);
        snd_write(0, 32'h0000_0B02);
        @(negedge clk);
        rcv_addr = 0; rcv_rd = 1'b1;
        snd_addr = 0; snd_wdata = 32'h0000_0C02; snd_wr = 1'b1;
        #1 v = rcv_rdata;
        @(negedge clk); rcv_rd = 1'b0; snd_wr = 1'b0;
        check("R9 old cmd returned", v, 32'h0000_0B02);
        rcv_read(2, v); check("R9 full no overflow", v, 32'd1);
        rcv_read(1, v); check("R9 ptr", v, 32'h0000_0B01);
        rcv_read(0, v); check("R9 new cmd", v, 32'h0000_0C02);

        // R10 receiver cannot write message words
        rcv_write(0, 32'hDEAD_0000);
        rcv_write(1, 32'hDEAD_0001);
        rcv_read(0, v); check("R10 cmd unchanged", v, 32'h0000_0C02);
        rcv_read(1, v); check("R10 ptr unchanged", v, 32'h0000_0B01);
        rcv_read(2, v); check("R10 still empty", v, 32'd2);
        snd_peek(3, v); check("R10 snd offset3", v, 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule